// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block runs ahead of the execution unit. It reads instruction bytes from memory and stores them in a small byte queue. Each read is a word on a 16-bit bus. The block keeps a 16-bit code segment and a 16-bit fetch pointer. It forms the 20-bit physical fetch address by shifting the segment left four bits and adding the pointer. A read request goes to the bus arbiter only when all of these hold:

- no earlier read is still outstanding;
- the queue has room for a full word;
- the execution unit is not asking for the bus for its own data access.

The execution unit takes bytes from the head of the queue over a valid/ready stream. A byte moves on a clock edge where both `byte_valid_o` and `byte_ready_i` are high. While `byte_valid_o` is high and `byte_ready_i` is low, the head byte holds steady. The consumer may hold `byte_ready_i` low for as long as it likes. While the queue is empty, `byte_valid_o` stays low.

A taken branch, call or return pulses `flush_i` together with a new segment and pointer. The flush empties the queue at once and restarts fetching from the new target. If a read is outstanding when the flush arrives, its data is thrown away when it returns. If the fetch pointer is odd, only the upper byte lane of the returned word is kept. All later reads then fall on word boundaries.

Top module: `pfq_top`

## Requirements
- R1: After reset, the queue is empty, `byte_valid_o` is 0, and the fetch address is 20'hFFFF0 (segment 16'hFFFF, pointer 16'h0000). A request is raised at once if `eu_data_req_i` is low.
- R2: When `fetch_req_o` is high, `fetch_addr_o` equals (segment × 16 + pointer) modulo 2^20. The pointer itself wraps at 16 bits.
- R3: `fetch_req_o` is high only when all three hold: no read is outstanding, at least two queue slots are free, and `flush_i` is low. A read counts as outstanding from the edge where `fetch_req_o` and `fetch_gnt_i` are both high until the edge where `rdata_valid_i` is sampled high.
- R4: While `eu_data_req_i` is high, `fetch_req_o` stays low.
- R5: If the pointer is even, a response queues `rdata_i[7:0]` first, then `rdata_i[15:8]`, and the pointer advances by 2.
- R6: If the pointer is odd, a response queues only `rdata_i[15:8]`, and the pointer advances by 1.
- R7: `byte_valid_o` is high exactly when the queue holds a byte and `flush_i` is low. `byte_o` is always the oldest byte. While valid is high and ready is low, the same byte stays presented on the next cycle unless a flush arrives.
- R8: The queue never holds more than six bytes, and bytes leave in the order they were queued.
- R9: A cycle with `flush_i` high empties the queue and loads `flush_cs_i` and `flush_ip_i`. The next request uses the new target.
- R10: A read outstanding when a flush arrives has its response discarded. No new request is raised until that response has come back.
- R11: A response that arrives in the same cycle as a flush is discarded.
- R12: When a byte is popped in the same cycle as a response is written, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Control transfer: empty the queue and load a new target |
| flush_cs_i | input | 16 | New code segment, loaded on flush |
| flush_ip_i | input | 16 | New fetch pointer, loaded on flush |
| eu_data_req_i | input | 1 | Execution unit wants the bus for data; takes priority |
| fetch_req_o | output | 1 | Word read request to the bus arbiter |
| fetch_addr_o | output | 20 | Physical address of the requested read |
| fetch_gnt_i | input | 1 | Arbiter accepts the request in this cycle |
| rdata_valid_i | input | 1 | Read data for the outstanding request is present |
| rdata_i | input | 16 | Returned word; the even byte is on bits 7:0 |
| byte_valid_o | output | 1 | Head byte is available |
| byte_o | output | 8 | Head byte |
| byte_ready_i | input | 1 | Execution unit takes the head byte |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is a returning read and a pop at the head. The random phase keeps `byte_ready_i` high most of the time and returns reads after 0 to 3 cycles, so writes and pops often share a cycle. Every popped byte is compared with the memory image at the address the bench expects to be next.

The second pair is a flush and the return of the read it makes stale. Directed cases put the flush in the same cycle as the response, and also one cycle before it. In both cases the bytes that follow must all come from the new target, and no new request may appear while the stale read is still outstanding.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  parameter int SEG_W = 16;
  parameter int PA_W = 20;
  localparam int SEG_SHIFT = PA_W - SEG_W;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/pfq_addr_gen.sv
module pfq_addr_gen
  import pfq_pkg::*;
(
  input  logic [SEG_W-1:0] seg_i,
  input  logic [SEG_W-1:0] ofs_i,
  output logic [PA_W-1:0]  phys_o
);
  // segment scaled by 16 plus zero-extended offset, carry out of bit 19 lost
  assign phys_o = {seg_i, {SEG_SHIFT{1'b0}}} + PA_W'(ofs_i);
endmodule

// File: rtl/pfq_byte_queue.sv
module pfq_byte_queue
  import pfq_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [1:0]       wr_cnt_i,
  input  byte_t            wr_lo_i,
  input  byte_t            wr_hi_i,
  input  logic             rd_i,
  output byte_t            head_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PTR_W-1:0] wp, rp, wp_nx;
  byte_t slot [DEPTH];

  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign wp_nx = step_ptr(wp);

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    byte_t q;
    logic  we_first, we_second;
    assign we_first  = (wr_cnt_i != 2'd0) && (wp == PTR_W'(gi));
    assign we_second = (wr_cnt_i == 2'd2) && (wp_nx == PTR_W'(gi));
    always_ff @(posedge clk) begin
      if (!clr_i) begin
        if (we_first)       q <= wr_lo_i;
        else if (we_second) q <= wr_hi_i;
      end
    end
    assign slot[gi] = q;
  end

  assign head_o = slot[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      count_o <= '0;
    end else if (clr_i) begin
      wp      <= '0;
      rp      <= '0;
      count_o <= '0;
    end else begin
      if (rd_i) rp <= step_ptr(rp);
      if (wr_cnt_i == 2'd1)      wp <= wp_nx;
      else if (wr_cnt_i == 2'd2) wp <= step_ptr(wp_nx);
      count_o <= count_o + CNT_W'(wr_cnt_i) - CNT_W'(rd_i);
    end
  end
endmodule

// File: rtl/pfq_fetch_ctl.sv
module pfq_fetch_ctl
  import pfq_pkg::*;
#(
  parameter int              DEPTH    = 6,
  parameter int              MIN_FREE = 2,
  parameter int              CNT_W    = $clog2(DEPTH + 1),
  parameter logic [SEG_W-1:0] RESET_CS = 16'hFFFF,
  parameter logic [SEG_W-1:0] RESET_IP = 16'h0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic [SEG_W-1:0] new_cs_i,
  input  logic [SEG_W-1:0] new_ip_i,
  input  logic             eu_data_req_i,
  input  logic             fetch_gnt_i,
  input  logic             rdata_valid_i,
  input  logic [15:0]      rdata_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [SEG_W-1:0] cs_o,
  output logic [SEG_W-1:0] ip_o,
  output logic             fetch_req_o,
  output logic [1:0]       wr_cnt_o,
  output byte_t            wr_lo_o,
  output byte_t            wr_hi_o
);
  logic             inflight, drop;
  logic             accept, odd;
  logic [CNT_W-1:0] free_slots;

  assign free_slots  = CNT_W'(DEPTH) - count_i;
  assign odd         = ip_o[0];
  assign fetch_req_o = !inflight && (free_slots >= CNT_W'(MIN_FREE))
                       && !flush_i && !eu_data_req_i;
  assign accept      = rdata_valid_i && inflight && !drop && !flush_i;
  assign wr_cnt_o    = accept ? (odd ? 2'd1 : 2'd2) : 2'd0;
  assign wr_lo_o     = odd ? rdata_i[15:8] : rdata_i[7:0];
  assign wr_hi_o     = rdata_i[15:8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_o     <= RESET_CS;
      ip_o     <= RESET_IP;
      inflight <= 1'b0;
      drop     <= 1'b0;
    end else if (flush_i) begin
      cs_o     <= new_cs_i;
      ip_o     <= new_ip_i;
      inflight <= inflight && !rdata_valid_i;
      drop     <= inflight && !rdata_valid_i;
    end else if (rdata_valid_i && inflight) begin
      inflight <= 1'b0;
      drop     <= 1'b0;
      if (!drop) ip_o <= ip_o + (odd ? 16'd1 : 16'd2);
    end else if (fetch_req_o && fetch_gnt_i) begin
      inflight <= 1'b1;
    end
  end
endmodule

// File: rtl/pfq_top.sv
module pfq_top
  import pfq_pkg::*;
#(
  parameter int               DEPTH    = 6,
  parameter int               MIN_FREE = 2,
  parameter logic [SEG_W-1:0] RESET_CS = 16'hFFFF,
  parameter logic [SEG_W-1:0] RESET_IP = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush_i,
  input  logic [15:0] flush_cs_i,
  input  logic [15:0] flush_ip_i,
  input  logic        eu_data_req_i,
  output logic        fetch_req_o,
  output logic [19:0] fetch_addr_o,
  input  logic        fetch_gnt_i,
  input  logic        rdata_valid_i,
  input  logic [15:0] rdata_i,
  output logic        byte_valid_o,
  output logic [7:0]  byte_o,
  input  logic        byte_ready_i
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] q_count;
  logic [SEG_W-1:0] cur_cs, cur_ip;
  logic [1:0]       wr_cnt;
  byte_t            wr_lo, wr_hi;
  logic             pop;

  assign byte_valid_o = (q_count != '0) && !flush_i;
  assign pop          = byte_valid_o && byte_ready_i;

  pfq_fetch_ctl #(
    .DEPTH(DEPTH), .MIN_FREE(MIN_FREE), .CNT_W(CNT_W),
    .RESET_CS(RESET_CS), .RESET_IP(RESET_IP)
  ) ctl_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .new_cs_i(flush_cs_i), .new_ip_i(flush_ip_i),
    .eu_data_req_i(eu_data_req_i), .fetch_gnt_i(fetch_gnt_i),
    .rdata_valid_i(rdata_valid_i), .rdata_i(rdata_i), .count_i(q_count),
    .cs_o(cur_cs), .ip_o(cur_ip), .fetch_req_o(fetch_req_o),
    .wr_cnt_o(wr_cnt), .wr_lo_o(wr_lo), .wr_hi_o(wr_hi)
  );

  pfq_addr_gen addr_i (
    .seg_i(cur_cs), .ofs_i(cur_ip), .phys_o(fetch_addr_o)
  );

  pfq_byte_queue #(.DEPTH(DEPTH), .CNT_W(CNT_W)) queue_i (
    .clk(clk), .rst_n(rst_n), .clr_i(flush_i),
    .wr_cnt_i(wr_cnt), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi),
    .rd_i(pop), .head_o(byte_o), .count_o(q_count)
  );
endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
  parameter int DEPTH    = 6,
  parameter int MIN_FREE = 2,
  parameter int CNT_W    = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush_i,
  input logic             eu_data_req_i,
  input logic             byte_ready_i,
  input logic             fetch_req_o,
  input logic             byte_valid_o,
  input logic [7:0]       byte_o,
  input logic [CNT_W-1:0] count
);
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  p_eu_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eu_data_req_i |-> !fetch_req_o);

  p_room_for_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req_o |-> (CNT_W'(DEPTH) - count >= CNT_W'(MIN_FREE)));

  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (count == '0));

  p_stall_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid_o && !byte_ready_i) |=> (flush_i || (byte_valid_o && $stable(byte_o))));
endmodule

bind pfq_top pfq_checker #(.DEPTH(DEPTH), .MIN_FREE(MIN_FREE), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .eu_data_req_i(eu_data_req_i),
  .byte_ready_i(byte_ready_i), .fetch_req_o(fetch_req_o),
  .byte_valid_o(byte_valid_o), .byte_o(byte_o), .count(q_count)
);

// File: tb/pfq_top_tb_top.sv
module pfq_top_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, flush, eu_req, gnt, rvalid, ready;
  logic [15:0] ncs, nip, rdata;
  logic freq, bvalid;
  logic [19:0] faddr;
  logic [7:0] bbyte;

  pfq_top dut_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush), .flush_cs_i(ncs), .flush_ip_i(nip),
    .eu_data_req_i(eu_req), .fetch_req_o(freq), .fetch_addr_o(faddr),
    .fetch_gnt_i(gnt), .rdata_valid_i(rvalid), .rdata_i(rdata),
    .byte_valid_o(bvalid), .byte_o(bbyte), .byte_ready_i(ready)
  );

  int checks = 0, fails = 0;
  logic [15:0] mcs, mip, fcs, fip;
  bit outstanding, stale, pend, hold_v, last_pop;
  logic [19:0] pend_addr;
  logic [7:0] hold_b;
  int pend_dly, lat_lo, lat_hi;

  function automatic logic [7:0] memb(input logic [19:0] a);
    logic [19:0] t;
    t = a * 20'd13 ^ (a >> 7);
    return t[7:0] ^ a[19:12] ^ 8'h5A;
  endfunction

  function automatic logic [19:0] phys(input logic [15:0] cs, input logic [15:0] ip);
    return {cs, 4'h0} + {4'h0, ip};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input bit fl, input logic [15:0] tcs, input logic [15:0] tip,
                      input bit rdy, input bit g, input bit eu);
    bit resp_now, grant;
    @(negedge clk);
    flush = fl; ncs = tcs; nip = tip; ready = rdy; gnt = g; eu_req = eu;
    resp_now = 0;
    if (pend && pend_dly == 0) begin
      rvalid = 1'b1;
      rdata = {memb(pend_addr | 20'h1), memb(pend_addr & ~20'h1)};
      resp_now = 1; pend = 0;
    end else begin
      rvalid = 1'b0; rdata = 16'hDEAD;
      if (pend) pend_dly--;
    end
    #1;
    if (hold_v && !fl) chk(bvalid && bbyte == hold_b, "R7 stalled byte held", {23'd0, bvalid, bbyte}, {24'd1, hold_b});
    if (fl) chk(!bvalid, "R9 valid low in flush cycle", bvalid, 0);
    if (eu) chk(!freq, "R4 data access first", freq, 0);
    if (freq) chk(!outstanding, "R3 R10 one read at a time", outstanding, 0);
    if (freq) chk(faddr == phys(fcs, fip), "R2 fetch address", faddr, phys(fcs, fip));
    last_pop = bvalid && rdy;
    if (last_pop) begin
      // R5 R6 R8 R11 R12: every byte leaves in address order from the current target
      chk(bbyte == memb(phys(mcs, mip)), "R5 R6 R12 byte order", bbyte, memb(phys(mcs, mip)));
      mip++;
    end
    hold_v = bvalid && !rdy; hold_b = bbyte;
    if (resp_now) begin
      if (!stale && !fl) fip = fip + (fip[0] ? 16'd1 : 16'd2);
      stale = 0; outstanding = 0;
    end
    grant = freq && g;
    if (fl) begin
      if (outstanding) stale = 1;
      fcs = tcs; fip = tip; mcs = tcs; mip = tip; hold_v = 0;
    end
    if (grant) begin
      outstanding = 1; pend = 1; pend_addr = faddr;
      pend_dly = $urandom_range(lat_hi, lat_lo);
    end
  endtask

  task automatic drain_count(input logic [31:0] exp, input string req);
    int n = 0;
    for (int i = 0; i < 12; i++) begin
      step(0, 0, 0, 1, 0, 0);
      if (last_pop) n++;
    end
    chk(n == exp, req, n, exp);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    rst_n = 0; flush = 0; ncs = 0; nip = 0; eu_req = 0; gnt = 0; rvalid = 0; ready = 0; rdata = 0;
    mcs = 16'hFFFF; mip = 0; fcs = 16'hFFFF; fip = 0;
    outstanding = 0; stale = 0; pend = 0; hold_v = 0; hold_b = 0; pend_dly = 0; pend_addr = 0;
    lat_lo = 0; lat_hi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(!bvalid, "R1 empty after reset", bvalid, 0);
    chk(freq, "R1 request after reset", freq, 1);
    chk(faddr == 20'hFFFF0, "R1 reset address", faddr, 20'hFFFF0);

    // R8 fill from even pointer: 6 bytes, then requests stop
    step(1, 16'h1234, 16'h0010, 0, 0, 0);
    for (int i = 0; i < 30; i++) step(0, 0, 0, 0, 1, 0);
    chk(!freq && bvalid, "R3 R8 full queue stops fetching", {bvalid, freq}, 2'b10);
    drain_count(6, "R8 six bytes held");

    // R6 odd pointer: 1 + 2 + 2 bytes, then free slots drop to one
    step(1, 16'h2000, 16'h0003, 0, 0, 0);
    for (int i = 0; i < 30; i++) step(0, 0, 0, 0, 1, 0);
    drain_count(5, "R6 odd start keeps one byte");

    // R2 wrap cases
    step(1, 16'hF000, 16'hFFFE, 1, 0, 0);
    for (int i = 0; i < 20; i++) step(0, 0, 0, 1, 1, 0);
    step(1, 16'hFFFF, 16'hFFF8, 1, 0, 0);
    for (int i = 0; i < 20; i++) step(0, 0, 0, 1, 1, 0);

    // R4 data access holds off prefetch
    step(1, 16'h0400, 16'h0000, 1, 0, 0);
    for (int i = 0; i < 10; i++) step(0, 0, 0, 1, 1, 1);
    chk(!bvalid, "R4 no bytes while data access", bvalid, 0);

    // R10 flush one cycle before stale response
    lat_lo = 1; lat_hi = 1;
    step(1, 16'h0500, 16'h0000, 1, 0, 0);
    step(0, 0, 0, 1, 1, 0);
    step(1, 16'h0600, 16'h0041, 1, 0, 0);
    for (int i = 0; i < 15; i++) step(0, 0, 0, 1, 1, 0);

    // R11 flush in the same cycle as the response
    lat_lo = 0; lat_hi = 0;
    step(1, 16'h0700, 16'h0000, 1, 0, 0);
    step(0, 0, 0, 1, 1, 0);
    step(1, 16'h0800, 16'h0022, 1, 0, 0);
    for (int i = 0; i < 15; i++) step(0, 0, 0, 1, 1, 0);

    // random mix: R12 push and pop overlap
    lat_lo = 0; lat_hi = 3;
    for (int i = 0; i < 4000; i++) begin
      bit fl;
      fl = ($urandom_range(49, 0) == 0);
      step(fl, 16'($urandom), 16'($urandom), $urandom_range(9, 0) < 7,
           $urandom_range(9, 0) < 6, $urandom_range(4, 0) == 0);
    end
    finish_run();
  end
endmodule